// File: doc/BRIEF.md
# Gated 13-Bit Timer/Counter

This block is one timer/counter channel that runs in a 13-bit mode. The count is held in two bytes. An 8-bit high byte sits above the five low bits of a low byte, and the top three bits of the low byte take no part. The channel counts one of two sources. The first is a tick from an internal prescaler, which divides the clock by 6 or by 12. The second is a falling edge on an external count pin. A gate option stops counting while an external gate pin is low, so software can measure how long that pin stays high.

When the count wraps from 0x1FFF to zero, the block sets an overflow flag. If the toggle option is on, the same wrap also inverts a toggle output. The flag is cleared by an interrupt acknowledge pulse or by a software write. Software reads and writes the low byte, the high byte and a control byte through a simple register port. Writes land at the clock edge and reads are combinational.

Falling edges on the count pin are found by a two-state machine that runs after a two-flop synchronizer. It has two states. `EDGE_HIGH` means the synchronized pin was last seen high, and `EDGE_LOW` means it was last seen low. The machine takes these transitions:
- `EDGE_HIGH` to `EDGE_LOW` when the pin is seen low. This transition emits a one-cycle edge event.
- `EDGE_LOW` to `EDGE_HIGH` when the pin is seen high again.
- In either state, it stays put while the pin holds its level.

Top module: `tmr13_gated`

## Requirements
- R1: After reset, these all read 0: the low byte, the high byte and the control byte. The `ovf_flag`, `tog_out` and `tog_oe` outputs are also 0.
- R2: The `wr_sel`/`rd_sel` code selects the register: 0 is the low byte, 1 is the high byte and 2 is the control byte. A low-byte write keeps only bits 4:0, and bits 7:5 of the low byte always read 0. The high byte is read and written whole.
- R3: Timer mode uses control bit 2 = 0, with control bit 3 = 1 for divide-by-6 and 0 for divide-by-12 (N). The run bit (control bit 0) is set at one write edge and cleared at a write edge C cycles later. Over that span the count advances by floor(C/N).
- R4: When bits 4:0 of the low byte wrap from 31 to 0, the high byte increments.
- R5: With the gate bit (control bit 1) set and `gate_pin` low, the count does not change. With `gate_pin` high, counting proceeds as if ungated.
- R6: In counter mode (control bit 2 = 1), each falling edge on `cnt_pin_in` adds exactly one to the count. This holds when the pin's low and high phases each last at least 3 cycles. The prescaler has no effect in this mode.
- R7: Setting the run bit does not clear the count. A stopped count resumes from its held value.
- R8: A wrap of the 13-bit count from 0x1FFF to 0 sets the overflow flag. The flag appears on `ovf_flag` and as control bit 5.
- R9: An `intr_ack` pulse clears the flag on the next edge. A control write loads the flag from bit 5.
- R10: When an overflow coincides with a control write of 0 to bit 5, the flag ends up set.
- R11: When control bit 4 is set, each overflow inverts `tog_out`, and `tog_oe` follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 8 | Read data (combinational) |
| cnt_pin_in | input | 1 | External count pin level |
| gate_pin | input | 1 | External gate pin |
| intr_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ovf_flag | output | 1 | Overflow flag |
| tog_out | output | 1 | Level driven back on the count pin |
| tog_oe | output | 1 | Output enable for `tog_out` |

## Verification
The assertions check these properties on every cycle:
- The count holds whenever there is neither a step nor a write.
- The prescaler advances by one between ticks and emits no tick while counting is disabled.
- Each edge event moves the detector into `EDGE_LOW`.
- An overflow always leaves the flag set.
- `tog_out` changes only on an enabled overflow.

Some properties need whole scenarios, which only the bench can show:
- the exact count after a run window, for each divider;
- gating against the pin level;
- one count per pin pulse;
- resuming from a held value;
- the clearing of the flag and its priority over a coinciding write.

// File: rtl/tmr13_pkg.sv
package tmr13_pkg;
    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_CTRL = 2'd2
    } regsel_e;

    localparam int CTL_RUN  = 0;
    localparam int CTL_GATE = 1;
    localparam int CTL_CNT  = 2;
    localparam int CTL_FAST = 3;
    localparam int CTL_TOG  = 4;
    localparam int CTL_FLAG = 5;

    typedef struct packed {
        logic tog_en;
        logic fast;
        logic cnt_mode;
        logic gate;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/tmr13_prescale.sv
module tmr13_prescale #(
    parameter int DIV_FAST = 6,
    parameter int DIV_SLOW = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast_sel,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW + 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim  = fast_sel ? PW'(DIV_FAST) : PW'(DIV_SLOW);
        tick = en && (cnt_q >= lim - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!en)    cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R3
    presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tmr13_edge_fsm.sv
module tmr13_edge_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic fall_evt
);
    typedef enum logic {EDGE_HIGH, EDGE_LOW} edge_st_e;

    edge_st_e st_q, st_d;
    logic sync1_q, sync2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDGE_HIGH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        fall_evt = 1'b0;
        unique case (st_q)
            EDGE_HIGH: if (!sync2_q) begin
                st_d     = EDGE_LOW;
                fall_evt = 1'b1;
            end
            EDGE_LOW:  if (sync2_q) st_d = EDGE_HIGH;
            default:   st_d = EDGE_HIGH;
        endcase
    end

    // R6
    edge_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> (st_q == EDGE_LOW));
endmodule

// File: rtl/tmr13_count_core.sv
module tmr13_count_core #(
    parameter int HI_W = 8,
    parameter int LO_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [7:0]      wr_data,
    output logic [LO_W-1:0] lo_q,
    output logic [HI_W-1:0] hi_q,
    output logic            ovf
);
    localparam int CW = HI_W + LO_W;

    logic [CW-1:0] cnt_q;
    logic          any_wr;

    assign lo_q   = cnt_q[LO_W-1:0];
    assign hi_q   = cnt_q[CW-1:LO_W];
    assign any_wr = wr_lo || wr_hi;
    assign ovf    = step && !any_wr && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_lo) cnt_q[LO_W-1:0] <= wr_data[LO_W-1:0];
            if (wr_hi) cnt_q[CW-1:LO_W] <= wr_data[HI_W-1:0];
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !any_wr) |=> $stable(cnt_q));

    // R4
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !any_wr && (&lo_q) && !(&hi_q)) |=> (hi_q == $past(hi_q) + 1'b1));
endmodule

// File: rtl/tmr13_gated.sv
module tmr13_gated #(
    parameter int DIV_FAST = 6,
    parameter int DIV_SLOW = 12,
    parameter int HI_W     = 8,
    parameter int LO_W     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    input  logic       cnt_pin_in,
    input  logic       gate_pin,
    input  logic       intr_ack,
    output logic       ovf_flag,
    output logic       tog_out,
    output logic       tog_oe
);
    import tmr13_pkg::*;

    ctrl_t ctl_q;
    logic  flag_q, tog_q;
    logic  gate_s1_q, gate_s2_q;
    logic  count_en, presc_tick, fall_evt, step, core_ovf;
    logic  wr_lo, wr_hi, wr_ctl;
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    assign wr_lo  = wr_en && (wr_sel == SEL_LOW);
    assign wr_hi  = wr_en && (wr_sel == SEL_HIGH);
    assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_s1_q <= 1'b0;
            gate_s2_q <= 1'b0;
        end else begin
            gate_s1_q <= gate_pin;
            gate_s2_q <= gate_s1_q;
        end
    end

    assign count_en = ctl_q.run && (!ctl_q.gate || gate_s2_q);
    assign step     = count_en && (ctl_q.cnt_mode ? fall_evt : presc_tick);

    tmr13_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) presc_i (
        .clk(clk), .rst_n(rst_n),
        .en(count_en && !ctl_q.cnt_mode),
        .fast_sel(ctl_q.fast), .tick(presc_tick)
    );

    tmr13_edge_fsm edge_i (
        .clk(clk), .rst_n(rst_n), .pin_in(cnt_pin_in), .fall_evt(fall_evt)
    );

    tmr13_count_core #(.HI_W(HI_W), .LO_W(LO_W)) core_i (
        .clk(clk), .rst_n(rst_n), .step(step),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .lo_q(lo_q), .hi_q(hi_q), .ovf(core_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            flag_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            if (wr_ctl) ctl_q <= ctrl_t'(wr_data[CTL_TOG:CTL_RUN]);
            if (core_ovf)      flag_q <= 1'b1;
            else if (wr_ctl)   flag_q <= wr_data[CTL_FLAG];
            else if (intr_ack) flag_q <= 1'b0;
            if (core_ovf && ctl_q.tog_en) tog_q <= !tog_q;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_LOW:  rd_data[LO_W-1:0] = lo_q;
            SEL_HIGH: rd_data[HI_W-1:0] = hi_q;
            SEL_CTRL: rd_data[CTL_FLAG:0] = {flag_q, ctl_q};
            default:  rd_data = '0;
        endcase
    end

    assign ovf_flag = flag_q;
    assign tog_out  = tog_q;
    assign tog_oe   = ctl_q.tog_en;

    // R10
    ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ovf |=> ovf_flag);

    // R11
    tog_only_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tog_out) |-> $past(core_ovf && ctl_q.tog_en));

    // R5
    no_tick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |-> !presc_tick);
endmodule

// File: tb/tmr13_gated_tb.sv
module tmr13_gated_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       cnt_pin_in = 1'b1;
    logic       gate_pin = 1'b0;
    logic       intr_ack = 1'b0;
    logic       ovf_flag, tog_out, tog_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr13_gated dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cnt_pin_in(cnt_pin_in), .gate_pin(gate_pin), .intr_ack(intr_ack),
        .ovf_flag(ovf_flag), .tog_out(tog_out), .tog_oe(tog_oe)
    );

    function automatic int div_of(bit fast);
        return fast ? 6 : 12;
    endfunction

    function automatic int exp_count(int start, int cyc, bit fast);
        return (start + cyc / div_of(fast)) % 8192;
    endfunction

    function automatic bit exp_wrap(int start, int cyc, bit fast);
        return (start + cyc / div_of(fast)) >= 8192;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        rd_sel = sel;
        #1 val = rd_data;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_count(output int val);
        logic [7:0] l, h;
        rd(2'd0, l);
        rd(2'd1, h);
        val = {h, l[4:0]};
    endtask

    task automatic set_count(input int val);
        wr(2'd0, 8'(val & 31) | 8'he0);
        wr(2'd1, 8'(val >> 5));
    endtask

    task automatic run_window(input logic [7:0] bits, input int cyc, input bit force_clr);
        logic [7:0] c;
        rd(2'd2, c);
        wr(2'd2, bits | 8'h01 | (c & 8'h20));
        repeat (cyc - 1) @(posedge clk);
        rd_sel = 2'd2;
        #1 c = rd_data;
        if (force_clr) c = 8'h00;
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = (bits & 8'hfe) | (c & 8'h20);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_pin(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_pin_in = 1'b0;
            repeat (3) @(negedge clk);
            cnt_pin_in = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int cnt, start, cyc, seed_val;
        bit fast, tgl, tog_before, wrap;

        seed_val = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check(v, 0, "R1 low");
        rd(2'd1, v); check(v, 0, "R1 high");
        rd(2'd2, v); check(v, 0, "R1 ctrl");
        check({ovf_flag, tog_out, tog_oe}, 0, "R1 outputs");

        // R2 register map
        wr(2'd0, 8'hff); rd(2'd0, v); check(v, 8'h1f, "R2 low masked");
        wr(2'd1, 8'ha5); rd(2'd1, v); check(v, 8'ha5, "R2 high");

        // R3 timer /12, then R7 resume
        set_count(0);
        run_window(8'h00, 100, 1'b0);
        rd_count(cnt); check(cnt, exp_count(0, 100, 1'b0), "R3 div12");
        run_window(8'h00, 50, 1'b0);
        rd_count(cnt); check(cnt, 12, "R7 resume");

        // R4 ripple into high byte
        set_count(16'h3 * 32 + 31);
        run_window(8'h08, 6, 1'b0);
        rd(2'd0, v); check(v, 0, "R4 low wrapped");
        rd(2'd1, v); check(v, 4, "R4 high carry");

        // R5 gating
        set_count(100);
        gate_pin = 1'b0;
        run_window(8'h02, 60, 1'b0);
        rd_count(cnt); check(cnt, 100, "R5 gated off");
        gate_pin = 1'b1;
        repeat (4) @(posedge clk);
        run_window(8'h02, 60, 1'b0);
        rd_count(cnt); check(cnt, 105, "R5 gate open");
        gate_pin = 1'b0;

        // R6 counter mode
        set_count(0);
        wr(2'd2, 8'h05);
        repeat (4) @(negedge clk);
        pulse_pin(7);
        repeat (6) @(negedge clk);
        wr(2'd2, 8'h04);
        rd_count(cnt); check(cnt, 7, "R6 edges");

        // R8 + R11 overflow via pin edge with toggle
        set_count(8191);
        wr(2'd2, 8'h15);
        check(tog_oe, 1, "R11 oe");
        pulse_pin(1);
        repeat (6) @(negedge clk);
        wr(2'd2, 8'h34);
        rd_count(cnt); check(cnt, 0, "R8 wrap");
        check(ovf_flag, 1, "R8 flag");
        rd(2'd2, v); check(v[5], 1, "R8 ctrl flag");
        check(tog_out, 1, "R11 toggled");

        // R9 ack and software access
        @(negedge clk) intr_ack = 1'b1;
        @(negedge clk) intr_ack = 1'b0;
        check(ovf_flag, 0, "R9 ack clear");
        wr(2'd2, 8'h20); check(ovf_flag, 1, "R9 sw set");
        wr(2'd2, 8'h00); check(ovf_flag, 0, "R9 sw clear");

        // R10 overflow wins against clearing write at same edge
        set_count(8191);
        run_window(8'h08, 6, 1'b1);
        check(ovf_flag, 1, "R10 priority");
        rd_count(cnt); check(cnt, 0, "R10 count");

        // R3 R8 R11 random windows
        for (int t = 0; t < 12; t++) begin
            fast  = 1'($urandom);
            tgl   = 1'($urandom);
            cyc   = 20 + int'($urandom % 180);
            start = (t % 2 == 0) ? (8160 + int'($urandom % 32)) : int'($urandom % 8192);
            set_count(start);
            wr(2'd2, {3'b000, tgl, fast, 3'b000});
            tog_before = tog_out;
            wrap = exp_wrap(start, cyc, fast);
            run_window({3'b000, tgl, fast, 3'b000}, cyc, 1'b0);
            rd_count(cnt); check(cnt, exp_count(start, cyc, fast), "R3 random count");
            check(ovf_flag, wrap, "R8 random flag");
            check(tog_out, tog_before ^ (wrap & tgl), "R11 random toggle");
        end

        finish_run();
    end
endmodule